// File: doc/BRIEF.md
# Prioritized DMA Transfer Sequencer

This block moves data for a set of DMA channels over one shared memory master port. A register file outside the block holds each channel's programmed source, destination, count and control word. The sequencer keeps the live state of every channel: its enable bit, working source and destination addresses, pending unit count and start delay. It moves one unit at a time. Each unit is a read from the working source followed by a write of the same data to the working destination.

After every unit the sequencer picks again among the channels that are enabled, have units left and have finished their start delay. The lowest channel index always wins, so an urgent channel can cut into a long block between two units. A channel starts when its start strobe arrives, or on a vertical- or horizontal-blank pulse that matches its timing mode. When a block finishes, the channel may stop or stay armed for the next blank, may reload its destination, and may raise an interrupt pulse. Access cost arrives on two small inputs, one for nonsequential and one for sequential accesses. The block has no wait-state tables of its own.

Top module: `dma_sequencer`

## Requirements
- R1: Among channels that are enabled, have a nonzero pending count and have finished their start delay, the lowest index is served. The choice is made again before every unit, so a lower-index channel that becomes ready runs before the rest of a higher-index block.
- R2: Control bit 4 selects the unit width: 0 means 2 bytes and `mem_size`=0, 1 means 4 bytes and `mem_size`=1.
- R3: Source control is bits [1:0] and destination control is bits [3:2]. Each uses 0 for increment, 1 for decrement, 2 for fixed and 3 for increment-with-reload. Each unit steps the address by that direction times the unit size.
- R4: On the first unit of a block, both addresses are rounded down to a multiple of the unit size, so every access is aligned to its size.
- R5: With the port always ready, the first read of a block is requested 7+`cost_nseq` cycles after the cycle that carries its trigger. Each later unit's read is requested 4+`cost_seq` cycles after the cycle in which the previous write was accepted. This covers the 2-cycle overhead, the access cost and the selection step.
- R6: When the last unit's write is accepted, the enable bit clears, unless repeat (bit 5) is set and the timing mode is not immediate.
- R7: At completion, a destination control of 3 reloads the working destination from the programmed destination.
- R8: At completion, if interrupt enable (bit 6) is set, `irq_pulse` for that channel is high for exactly one cycle, in the cycle after the final write is accepted.
- R9: Timing mode is bits [8:7]: 0 immediate, 1 vertical blank, 2 horizontal blank, 3 never. A start strobe enables the channel and loads its working addresses; in immediate mode it also loads the pending count. A blank pulse loads the pending count of every enabled channel in the matching mode whose pending count is zero. Pulses of the other mode have no effect. Loading a count starts a 3-cycle start delay. A programmed count of 0 means 2^CW units.
- R10: `cpu_stall` is high exactly while some enabled channel has a nonzero pending count.
- R11: A request keeps its address, direction and size stable until `mem_ready`. The write of a unit carries the data returned by its read. The next unit does not begin before the write is accepted.
- R12: A start strobe on a channel that is already enabled changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_start | input | NCH | Per-channel start strobe (enable written from 0 to 1) |
| cfg_src | input | NCH*AW | Programmed source addresses, channel i at [i*AW +: AW] |
| cfg_dst | input | NCH*AW | Programmed destination addresses |
| cfg_count | input | NCH*CW | Programmed unit counts |
| cfg_ctl | input | NCH*9 | Control words (fields as in R2, R3, R6, R8, R9) |
| vblank_pulse | input | 1 | Vertical-blank trigger |
| hblank_pulse | input | 1 | Horizontal-blank trigger |
| cost_nseq | input | CST_W | Cost in cycles of a nonsequential access pair |
| cost_seq | input | CST_W | Cost in cycles of a sequential access pair |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 1 | 0 = halfword, 1 = word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted this cycle |
| ch_enable | output | NCH | Live enable bit per channel |
| irq_pulse | output | NCH | One-cycle completion interrupt per channel |
| cpu_stall | output | 1 | Processor hold while any transfer is pending |

## Verification
A vertical-blank and a horizontal-blank pulse can arrive in the same cycle, and each can arm a different channel. The bench fires both at once while one channel of each mode is idle but enabled. The scoreboard then expects every unit of the lower-index channel before any unit of the higher one. A second case covers a start that lands while the memory port is stalled in the middle of a higher-index channel's first read. That unit must complete, and the newly armed lower-index channel must take over before the remaining units.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int CTL_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COST = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_st_e;

    localparam logic [1:0] AC_INC    = 2'd0;
    localparam logic [1:0] AC_DEC    = 2'd1;
    localparam logic [1:0] AC_FIX    = 2'd2;
    localparam logic [1:0] AC_RELOAD = 2'd3;

    localparam logic [1:0] TM_NOW  = 2'd0;
    localparam logic [1:0] TM_VBL  = 2'd1;
    localparam logic [1:0] TM_HBL  = 2'd2;
    localparam logic [1:0] TM_NONE = 2'd3;

    function automatic logic [1:0] f_sctl(input logic [CTL_W-1:0] c);
        return c[1:0];
    endfunction
    function automatic logic [1:0] f_dctl(input logic [CTL_W-1:0] c);
        return c[3:2];
    endfunction
    function automatic logic f_wide(input logic [CTL_W-1:0] c);
        return c[4];
    endfunction
    function automatic logic f_rep(input logic [CTL_W-1:0] c);
        return c[5];
    endfunction
    function automatic logic f_irq(input logic [CTL_W-1:0] c);
        return c[6];
    endfunction
    function automatic logic [1:0] f_tm(input logic [CTL_W-1:0] c);
        return c[8:7];
    endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N-1:0] seen;

    assign seen[0] = 1'b0;
    assign gnt[0]  = req[0];
    for (genvar g = 1; g < N; g++) begin : g_chain
        assign seen[g] = seen[g-1] | req[g-1];
        assign gnt[g]  = req[g] & ~seen[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = idx | IW'(i);
        end
    end

    assign any = |req;

    // R1: at most one channel granted
    p_onehot_gnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1: a granted channel must have no lower-index requester
    p_lowest_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (gnt != '0) && ((req & (gnt - 1'b1)) == '0));
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = 28
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    mode,
    input  logic          wide,
    input  logic          first,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] sz;

    always_comb begin
        sz  = wide ? AW'(4) : AW'(2);
        cur = first ? (base & ~(sz - AW'(1))) : base;
        case (mode)
            AC_DEC:  nxt = cur - sz;
            AC_FIX:  nxt = cur;
            default: nxt = cur + sz;
        endcase
    end
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
    import dma_seq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 28,
    parameter int CW    = 21,
    parameter int CST_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_start,
    input  logic [NCH*AW-1:0]    cfg_src,
    input  logic [NCH*AW-1:0]    cfg_dst,
    input  logic [NCH*CW-1:0]    cfg_count,
    input  logic [NCH*CTL_W-1:0] cfg_ctl,
    input  logic                 vblank_pulse,
    input  logic                 hblank_pulse,
    input  logic [CST_W-1:0]     cost_nseq,
    input  logic [CST_W-1:0]     cost_seq,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_size,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    input  logic                 mem_ready,
    output logic [NCH-1:0]       ch_enable,
    output logic [NCH-1:0]       irq_pulse,
    output logic                 cpu_stall
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PW  = CW + 1;
    localparam int CCW = CST_W + 2;

    typedef struct packed {
        seq_st_e                   st;
        logic [CIW-1:0]            sel;
        logic [CCW-1:0]            cost;
        logic [31:0]               rdata;
        logic [NCH-1:0]            en;
        logic [NCH-1:0]            first;
        logic [NCH-1:0]            irq;
        logic [NCH-1:0][PW-1:0]    pend;
        logic [NCH-1:0][1:0]       dly;
        logic [NCH-1:0][AW-1:0]    wsrc;
        logic [NCH-1:0][AW-1:0]    wdst;
    } state_t;

    state_t q, d;

    logic [NCH-1:0][CTL_W-1:0] ctl;
    logic [NCH-1:0][PW-1:0]    load_cnt;
    logic [NCH-1:0]            elig;
    logic [NCH-1:0]            busy;
    logic [NCH-1:0]            pk_gnt;
    logic [CIW-1:0]            pk_idx;
    logic                      pk_any;
    logic [AW-1:0]             src_cur, src_nxt, dst_cur, dst_nxt;
    logic [CTL_W-1:0]          sel_ctl;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] cnt_raw;
        assign ctl[g]      = cfg_ctl[g*CTL_W +: CTL_W];
        assign cnt_raw     = cfg_count[g*CW +: CW];
        assign load_cnt[g] = (cnt_raw == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cnt_raw};
        assign busy[g]     = q.en[g] && (q.pend[g] != '0);
        assign elig[g]     = busy[g] && (q.dly[g] == 2'd0);
    end

    dma_prio_pick #(.N(NCH), .IW(CIW)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (elig),
        .gnt   (pk_gnt),
        .idx   (pk_idx),
        .any   (pk_any)
    );

    assign sel_ctl = ctl[q.sel];

    dma_addr_unit #(.AW(AW)) u_src (
        .base  (q.wsrc[q.sel]),
        .mode  (f_sctl(sel_ctl)),
        .wide  (f_wide(sel_ctl)),
        .first (q.first[q.sel]),
        .cur   (src_cur),
        .nxt   (src_nxt)
    );

    dma_addr_unit #(.AW(AW)) u_dst (
        .base  (q.wdst[q.sel]),
        .mode  (f_dctl(sel_ctl)),
        .wide  (f_wide(sel_ctl)),
        .first (q.first[q.sel]),
        .cur   (dst_cur),
        .nxt   (dst_nxt)
    );

    always_comb begin
        d     = q;
        d.irq = '0;

        for (int i = 0; i < NCH; i++) begin
            if (q.dly[i] != 2'd0) d.dly[i] = q.dly[i] - 2'd1;
            if (ch_start[i] && !q.en[i]) begin
                d.en[i]   = 1'b1;
                d.wsrc[i] = cfg_src[i*AW +: AW];
                d.wdst[i] = cfg_dst[i*AW +: AW];
                if (f_tm(ctl[i]) == TM_NOW) begin
                    d.pend[i]  = load_cnt[i];
                    d.dly[i]   = 2'd3;
                    d.first[i] = 1'b1;
                end
            end else if (q.en[i] && (q.pend[i] == '0) &&
                         ((vblank_pulse && f_tm(ctl[i]) == TM_VBL) ||
                          (hblank_pulse && f_tm(ctl[i]) == TM_HBL))) begin
                d.pend[i]  = load_cnt[i];
                d.dly[i]   = 2'd3;
                d.first[i] = 1'b1;
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (pk_any) begin
                    d.sel  = pk_idx;
                    d.cost = CCW'(2) + CCW'(q.first[pk_idx] ? cost_nseq : cost_seq);
                    d.st   = ST_COST;
                end
            end
            ST_COST: begin
                if (q.cost <= CCW'(1)) d.st = ST_RD;
                else                    d.cost = q.cost - CCW'(1);
            end
            ST_RD: begin
                if (mem_ready) begin
                    d.rdata = mem_rdata;
                    d.st    = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    d.st           = ST_IDLE;
                    d.wsrc[q.sel]  = src_nxt;
                    d.wdst[q.sel]  = dst_nxt;
                    d.first[q.sel] = 1'b0;
                    d.pend[q.sel]  = q.pend[q.sel] - PW'(1);
                    if (q.pend[q.sel] == PW'(1)) begin
                        if (!(f_rep(sel_ctl) && f_tm(sel_ctl) != TM_NOW))
                            d.en[q.sel] = 1'b0;
                        if (f_dctl(sel_ctl) == AC_RELOAD)
                            d.wdst[q.sel] = cfg_dst[q.sel*AW +: AW];
                        if (f_irq(sel_ctl))
                            d.irq[q.sel] = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we    = (q.st == ST_WR);
    assign mem_addr  = (q.st == ST_WR) ? dst_cur : src_cur;
    assign mem_size  = f_wide(sel_ctl);
    assign mem_wdata = q.rdata;
    assign ch_enable = q.en;
    assign irq_pulse = q.irq;
    assign cpu_stall = |busy;

    // R11: a waiting request holds its address and direction
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

    // R4: every access aligned to its size
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size ? (mem_addr[1:0] == 2'b00) : (mem_addr[0] == 1'b0)));

    // R10: no memory traffic without the processor hold
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    // R8: interrupt only right after a write acceptance
    p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |-> $past(mem_req && mem_we && mem_ready));

    // R6: enable falls only at a write acceptance
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ch_enable & $past(ch_enable)) != '0) |-> $past(mem_req && mem_we && mem_ready));
endmodule

// File: tb/dma_sequencer_tb.sv
`timescale 1ns/1ps
module dma_sequencer_tb;
    localparam int NCH = 4, AW = 28, CW = 21, CTLW = 9, CST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]      ch_start = '0;
    logic [NCH*AW-1:0]   cfg_src = '0, cfg_dst = '0;
    logic [NCH*CW-1:0]   cfg_count = '0;
    logic [NCH*CTLW-1:0] cfg_ctl = '0;
    logic vblank_pulse = 1'b0, hblank_pulse = 1'b0;
    logic [CST-1:0] cost_nseq = 4'd3, cost_seq = 4'd1;
    logic mem_req, mem_we, mem_size, mem_ready, cpu_stall;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [NCH-1:0] ch_enable, irq_pulse;
    logic ready_r = 1'b1;

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'hBEEF, a[15:0]};
    endfunction

    assign mem_rdata = mem_fn(mem_addr);
    assign mem_ready = ready_r;

    dma_sequencer #(.NCH(NCH), .AW(AW), .CW(CW), .CST_W(CST)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .cfg_ctl(cfg_ctl), .vblank_pulse(vblank_pulse),
        .hblank_pulse(hblank_pulse), .cost_nseq(cost_nseq), .cost_seq(cost_seq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ch_enable(ch_enable), .irq_pulse(irq_pulse), .cpu_stall(cpu_stall)
    );

    typedef struct {
        bit             we;
        logic [AW-1:0]  addr;
        bit             size;
        logic [31:0]    data;
        string          tag;
    } item_t;

    item_t sbq[$];
    int gaps[$];
    int checks = 0, failures = 0;
    int cyc = 0, ref_cyc = 0;
    bit prev_req = 1'b0;
    bit done = 1'b0;
    int irq_cnt [NCH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops and compares accepted accesses
    initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) if (irq_pulse[i]) irq_cnt[i]++;
            if (mem_req && !mem_we && !prev_req) gaps.push_back(cyc - ref_cyc);
            if (mem_req && mem_ready) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9 unexpected access", {35'd0, mem_we, mem_addr}, 64'd0);
                end else begin
                    item_t e;
                    e = sbq.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr && mem_size == e.size,
                        {e.tag, " R11 access"}, {34'd0, mem_size, mem_we, mem_addr},
                        {34'd0, e.size, e.we, e.addr});
                    if (e.we) chk(mem_wdata == e.data, {e.tag, " R11 data"}, mem_wdata, e.data);
                end
                if (mem_we) ref_cyc = cyc;
            end
            prev_req = mem_req;
        end
    end

    function automatic logic [CTLW-1:0] mk_ctl(input logic [1:0] sc, input logic [1:0] dc,
            input bit wide, input bit rep, input bit irqen, input logic [1:0] tm);
        return {tm, irqen, rep, wide, dc, sc};
    endfunction

    task automatic set_cfg(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] dd,
                           input int cnt, input logic [CTLW-1:0] c);
        cfg_src[ch*AW +: AW]     = s;
        cfg_dst[ch*AW +: AW]     = dd;
        cfg_count[ch*CW +: CW]   = CW'(cnt);
        cfg_ctl[ch*CTLW +: CTLW] = c;
    endtask

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m, input int sz);
        if (m == 2'd1) return a - AW'(sz);
        if (m == 2'd2) return a;
        return a + AW'(sz);
    endfunction

    // driver side: push expected read/write pairs
    task automatic exp_units(input string tag, inout logic [AW-1:0] s, inout logic [AW-1:0] dd,
                             input logic [1:0] sc, input logic [1:0] dc, input bit wide,
                             input int n, input bit first);
        int sz = wide ? 4 : 2;
        if (first) begin
            s  = s & ~AW'(sz - 1);
            dd = dd & ~AW'(sz - 1);
        end
        for (int k = 0; k < n; k++) begin
            item_t r, w;
            r.we = 1'b0; r.addr = s;  r.size = wide; r.data = '0;        r.tag = tag;
            w.we = 1'b1; w.addr = dd; w.size = wide; w.data = mem_fn(s); w.tag = tag;
            sbq.push_back(r);
            sbq.push_back(w);
            s  = step(s, sc, sz);
            dd = step(dd, dc, sz);
        end
    endtask

    task automatic pulse_start(input int ch);
        @(negedge clk);
        ch_start[ch] = 1'b1;
        ref_cyc = cyc;
        @(negedge clk);
        ch_start = '0;
    endtask

    task automatic pulse_blank(input bit v, input bit h);
        @(negedge clk);
        vblank_pulse = v;
        hblank_pulse = h;
        ref_cyc = cyc;
        @(negedge clk);
        vblank_pulse = 1'b0;
        hblank_pulse = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 2000 && sbq.size() != 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, {tag, " scoreboard drained"}, sbq.size(), 0);
    endtask

    task automatic chk_gaps(input string tag, input int g0, input int gn, input int n);
        chk(gaps.size() == n, {tag, " gap count"}, gaps.size(), n);
        for (int k = 0; k < gaps.size() && k < n; k++)
            chk(gaps[k] == ((k == 0) ? g0 : gn), {tag, " R5 read start gap"}, gaps[k], (k == 0) ? g0 : gn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] s, dd, s0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!mem_req && !cpu_stall, "R10 reset idle", {mem_req, cpu_stall}, 0);
        chk(ch_enable == '0 && irq_pulse == '0, "R6 reset enables", {ch_enable, irq_pulse}, 0);

        // T_A: word, inc/inc, unaligned start, irq, immediate
        set_cfg(1, 28'h0102, 28'h0402, 3, mk_ctl(2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0));
        s = 28'h0102; dd = 28'h0402;
        exp_units("R2 R3 R4 word inc", s, dd, 2'd0, 2'd0, 1'b1, 3, 1'b1);
        gaps.delete();
        pulse_start(1);
        drain("R2");
        chk_gaps("R5 immediate", 10, 5, 3);
        chk(ch_enable[1] == 1'b0, "R6 immediate clears enable", ch_enable, 0);
        chk(irq_cnt[1] == 1, "R8 irq once", irq_cnt[1], 1);

        // T_B: half, dec src, fixed dst, repeat ignored in immediate mode
        set_cfg(2, 28'h0201, 28'h0301, 3, mk_ctl(2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0));
        s = 28'h0201; dd = 28'h0301;
        exp_units("R3 R4 half dec fixed", s, dd, 2'd1, 2'd2, 1'b0, 3, 1'b1);
        pulse_start(2);
        drain("R3");
        chk(ch_enable[2] == 1'b0, "R6 repeat+immediate clears", ch_enable, 0);
        chk(irq_cnt[2] == 0, "R8 no irq when disabled", irq_cnt[2], 0);

        // T_C: vblank, repeat, destination reload
        set_cfg(0, 28'h0500, 28'h0600, 2, mk_ctl(2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 2'd1));
        pulse_start(0);
        repeat (20) @(negedge clk);
        chk(ch_enable[0] && !cpu_stall && !mem_req, "R9 blank mode waits", {ch_enable[0], cpu_stall, mem_req}, 3'b100);
        pulse_blank(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        chk(!cpu_stall && !mem_req, "R9 other blank ignored", {cpu_stall, mem_req}, 0);
        s0 = 28'h0500; d0 = 28'h0600;
        exp_units("R7 first vblank", s0, d0, 2'd0, 2'd3, 1'b1, 2, 1'b1);
        gaps.delete();
        pulse_blank(1'b1, 1'b0);
        drain("R9");
        chk_gaps("R5 vblank", 10, 5, 2);
        chk(ch_enable[0] == 1'b1, "R6 repeat keeps enable", ch_enable[0], 1);
        chk(irq_cnt[0] == 1, "R8 vblank irq", irq_cnt[0], 1);
        d0 = 28'h0600;
        exp_units("R7 reload dst", s0, d0, 2'd0, 2'd3, 1'b1, 2, 1'b1);
        pulse_blank(1'b1, 1'b0);
        drain("R7");
        chk(irq_cnt[0] == 2, "R8 second irq", irq_cnt[0], 2);

        // T_D: preemption between units while the port stalls
        ready_r = 1'b0;
        set_cfg(3, 28'h0700, 28'h0800, 4, mk_ctl(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0));
        set_cfg(1, 28'h0900, 28'h0A00, 2, mk_ctl(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0));
        s = 28'h0700; dd = 28'h0800;
        exp_units("R1 ch3 first", s, dd, 2'd0, 2'd0, 1'b0, 1, 1'b1);
        begin
            logic [AW-1:0] s1, d1;
            s1 = 28'h0900; d1 = 28'h0A00;
            exp_units("R1 ch1 preempts", s1, d1, 2'd0, 2'd0, 1'b1, 2, 1'b1);
        end
        exp_units("R1 ch3 resumes", s, dd, 2'd0, 2'd0, 1'b0, 3, 1'b0);
        pulse_start(3);
        repeat (20) @(negedge clk);
        chk(cpu_stall == 1'b1, "R10 stall while pending", cpu_stall, 1);
        chk(mem_req && !mem_we && mem_addr == 28'h0700, "R11 held request", {mem_req, mem_we, mem_addr}, {2'b10, 28'h0700});
        pulse_start(1);
        repeat (10) @(negedge clk);
        ready_r = 1'b1;
        drain("R1");
        chk(ch_enable[1] == 1'b0 && ch_enable[3] == 1'b0, "R6 both cleared", ch_enable, 4'b0001);

        // T_E: both blank pulses together, ignored start on enabled ch0
        set_cfg(2, 28'h0B00, 28'h0C00, 1, mk_ctl(2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2));
        pulse_start(2);
        cfg_src[0 +: AW] = 28'h0F00;
        pulse_start(0);
        repeat (10) @(negedge clk);
        chk(!mem_req && !cpu_stall, "R12 start on enabled channel ignored", {mem_req, cpu_stall}, 0);
        d0 = 28'h0600;
        exp_units("R12 R1 ch0 continues", s0, d0, 2'd0, 2'd3, 1'b1, 2, 1'b1);
        s = 28'h0B00; dd = 28'h0C00;
        exp_units("R1 ch2 after ch0", s, dd, 2'd2, 2'd0, 1'b0, 1, 1'b1);
        pulse_blank(1'b1, 1'b1);
        drain("R9 dual");
        chk(irq_cnt[2] == 1 && irq_cnt[0] == 3, "R8 dual irq", {irq_cnt[2][3:0], irq_cnt[0][3:0]}, 8'h13);
        chk(ch_enable == 4'b0001, "R6 final enables", ch_enable, 4'b0001);
        chk(!cpu_stall, "R10 stall released", cpu_stall, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule